// File: doc/BRIEF.md
# Address Translation Cache with Command-Driven Invalidation

This block keeps a small fully associative store of finished address translations in front of a page-table walker. Each line holds a 20-bit virtual page number and a 2-bit address-space identifier as its tag, plus a physical frame number and an attribute field. A lookup compares the key against every active line in the same cycle and returns hit, frame and attributes. On a miss the block records one outstanding walk. The walker later answers it through the fill port, which writes the translation into a line chosen by a round-robin pointer.

Software controls the store through two write-only words and reads back three values. A single 32-bit command word invalidates lines. It can clear everything, a 4 MiB section or a 16 KiB group, and it can optionally be limited to one address-space identifier. A configuration word sets how many lines are in use, whether hits may be served while a walk is outstanding, and whether the hit and miss counters run. The configuration word and both counters are visible on output ports.

Top module: `xlat_tlb`

## Requirements
- R1: After reset the configuration word reads 0x20000010, both counters read zero and no line is valid.
- R2: A lookup hits only on a valid active line whose page number and identifier both equal the key. On a hit, frame and attributes appear combinationally in the same cycle. Otherwise `lk_hit` stays low.
- R3: Fills that find no matching tag go to the line at the round-robin pointer, which then advances and wraps at the active line count. The count is taken from configuration bits [4:0]; 0 or any value above the capacity means every line. A flush of all lines with identifier matching off also returns the pointer to line 0.
- R4: A fill whose page number and identifier are already held overwrites that line and does not advance the pointer, so a tag is never present twice.
- R5: Command bits [1:0] select the flush type. 0 hits every line. 2 hits lines whose page-number bits [19:10] equal command bits [19:10]. 3 hits lines whose page-number bits [19:2] equal command bits [19:2]. 1 changes nothing.
- R6: When command bit 31 is set, only lines whose identifier equals command bits [30:29] are flushed. When it is clear, lines of every identifier are eligible.
- R7: When a command write and a fill occur in the same cycle, the flush is applied and the fill is discarded.
- R8: A lookup that misses marks a walk outstanding. While a walk is outstanding, a further miss stalls. A lookup that would hit is answered if configuration bit 29 is set, and stalls if it is clear.
- R9: The hit and miss counters advance, once per accepted lookup, only while configuration bit 31 is set. Stalled lookups are not counted.
- R10: A fill ends the outstanding walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 2 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_stall | output | 1 | Lookup not accepted this cycle |
| lk_pfn | output | PFN_W | Frame number on a hit |
| lk_attr | output | ATTR_W | Attributes on a hit |
| fill_valid | input | 1 | Walker fill strobe |
| fill_vpn | input | 20 | Fill page number |
| fill_asid | input | 2 | Fill identifier |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_attr | input | ATTR_W | Fill attributes |
| cmd_we | input | 1 | Flush command write |
| cmd_data | input | 32 | Flush command word |
| cfg_we | input | 1 | Configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_q | output | 32 | Current configuration word |
| stat_hits | output | CNT_W | Hit counter |
| stat_misses | output | CNT_W | Miss counter |

## Verification
The bench aims at the places where a wrong design would still translate most addresses.

- Eviction order is checked by filling one line beyond capacity. A pointer that failed to wrap, or that skipped a line, would keep the oldest entry alive.
- A refill of an existing tag is checked by following it with a new tag. A design that duplicated the tag would leave the old copy hitting.
- Section and group flushes are mixed with identifier matching on neighbouring pages. A mask that is one bit off, or that ignores the identifier, would either spare or kill the wrong lines.
- The stall and counter rules are exercised with hit-under-miss on and off. A design that counted stalled lookups, or served hits while serving was disabled, would show wrong counts or a hit where a stall is due.
- A flush and a fill are issued in the same cycle. A design that let the fill win would leave the new page hitting.

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20,
  parameter int ATTR_W  = 3,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [19:0]       lk_vpn,
  input  logic [1:0]        lk_asid,
  output logic              lk_hit,
  output logic              lk_stall,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_valid,
  input  logic [19:0]       fill_vpn,
  input  logic [1:0]        fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_data,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  output logic [CNT_W-1:0]  stat_hits,
  output logic [CNT_W-1:0]  stat_misses
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LNS_W = IDX_W + 1;
  localparam logic [31:0] CFG_RST = 32'h2000_0010;

  logic [ENTRIES-1:0] vld;
  logic [19:0]        t_vpn  [ENTRIES];
  logic [1:0]         t_asid [ENTRIES];
  logic [PFN_W-1:0]   d_pfn  [ENTRIES];
  logic [ATTR_W-1:0]  d_attr [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic               pending;

  logic [LNS_W-1:0] lines_fld, active_n;
  assign lines_fld = cfg_q[LNS_W-1:0];
  assign active_n  = (lines_fld == '0 || lines_fld > LNS_W'(ENTRIES)) ? LNS_W'(ENTRIES) : lines_fld;

  logic hum_en, stat_en;
  assign hum_en  = cfg_q[29];
  assign stat_en = cfg_q[31];

  logic [ENTRIES-1:0] act, lk_match, fl_match, kill;
  logic [1:0] ftype;
  logic       id_en;
  assign ftype = cmd_data[1:0];
  assign id_en = cmd_data[31];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      act[i]      = LNS_W'(i) < active_n;
      lk_match[i] = vld[i] && act[i] && t_vpn[i] == lk_vpn && t_asid[i] == lk_asid;
      fl_match[i] = vld[i] && act[i] && t_vpn[i] == fill_vpn && t_asid[i] == fill_asid;
      case (ftype)
        2'd0:    kill[i] = 1'b1;
        2'd2:    kill[i] = t_vpn[i][19:10] == cmd_data[19:10];
        2'd3:    kill[i] = t_vpn[i][19:2] == cmd_data[19:2];
        default: kill[i] = 1'b0;
      endcase
      kill[i] = kill[i] && (!id_en || t_asid[i] == cmd_data[30:29]);
    end
  end

  logic lk_any;
  assign lk_any   = |lk_match;
  assign lk_stall = lk_valid && pending && (!hum_en || !lk_any);
  assign lk_hit   = lk_valid && !lk_stall && lk_any;

  logic accept;
  assign accept = lk_valid && !lk_stall;

  always_comb begin
    lk_pfn  = '0;
    lk_attr = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn | d_pfn[i];
        lk_attr = lk_attr | d_attr[i];
      end
  end

  logic             fl_any;
  logic [IDX_W-1:0] fl_idx, rr_base, widx, rr_next;
  logic [LNS_W-1:0] rr_inc;
  always_comb begin
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fl_match[i]) fl_idx = IDX_W'(i);
  end
  assign fl_any  = |fl_match;
  assign rr_base = ({1'b0, rr} >= active_n) ? '0 : rr;
  assign rr_inc  = {1'b0, rr_base} + 1'b1;
  assign rr_next = (rr_inc >= active_n) ? '0 : rr_inc[IDX_W-1:0];
  assign widx    = fl_any ? fl_idx : rr_base;

  logic do_fill;
  assign do_fill = fill_valid && !cmd_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld         <= '0;
      rr          <= '0;
      pending     <= 1'b0;
      cfg_q       <= CFG_RST;
      stat_hits   <= '0;
      stat_misses <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (cmd_we) begin
        vld <= vld & ~kill;
        if (ftype == 2'd0 && !id_en) rr <= '0;
      end else if (fill_valid) begin
        vld[widx] <= 1'b1;
        if (!fl_any) rr <= rr_next;
      end
      if (accept && !lk_any) pending <= 1'b1;
      else if (fill_valid)   pending <= 1'b0;
      if (stat_en && accept) begin
        if (lk_any) stat_hits   <= stat_hits + 1'b1;
        else        stat_misses <= stat_misses + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (do_fill) begin
      t_vpn[widx]  <= fill_vpn;
      t_asid[widx] <= fill_asid;
      d_pfn[widx]  <= fill_pfn;
      d_attr[widx] <= fill_attr;
    end

  // R4
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_match));

  // R5
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data[1:0] == 2'd0 && !cmd_data[31] |=> vld == '0);

  // R7
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (vld & ~$past(vld)) == '0);

  // R8
  no_hit_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !cfg_q[29] && lk_valid |-> !lk_hit);

  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[31] |=> $stable(stat_hits) && $stable(stat_misses));

  // R10
  walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && pending |=> !pending);
endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  localparam int PW = 20;
  localparam int AW = 3;
  localparam int CW = 32;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0;
  logic [19:0] lk_vpn = 0;
  logic [1:0] lk_asid = 0;
  logic lk_hit, lk_stall;
  logic [PW-1:0] lk_pfn;
  logic [AW-1:0] lk_attr;
  logic fill_valid = 0;
  logic [19:0] fill_vpn = 0;
  logic [1:0] fill_asid = 0;
  logic [PW-1:0] fill_pfn = 0;
  logic [AW-1:0] fill_attr = 0;
  logic cmd_we = 0;
  logic [31:0] cmd_data = 0;
  logic cfg_we = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_q;
  logic [CW-1:0] stat_hits, stat_misses;

  int checks = 0, failures = 0;
  logic r_hit, r_stall;
  logic [PW-1:0] r_pfn;
  logic [AW-1:0] r_attr;

  always #2 clk = ~clk;

  xlat_tlb u_xlat_tlb (.*);

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input [19:0] v, input [1:0] a);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    #1;
    r_hit = lk_hit; r_stall = lk_stall; r_pfn = lk_pfn; r_attr = lk_attr;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic expect_hit(input string req, input [19:0] v, input [1:0] a, input [PW-1:0] p);
    look(v, a);
    chk(req, r_hit && r_pfn == p, {r_hit, r_pfn}, {1'b1, p});
  endtask

  task automatic expect_miss(input string req, input [19:0] v, input [1:0] a);
    look(v, a);
    chk(req, !r_hit, r_hit, 0);
  endtask

  task automatic fill(input [19:0] v, input [1:0] a, input [PW-1:0] p, input [AW-1:0] t);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_attr = t;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic flush(input [31:0] c);
    cmd_we = 1; cmd_data = c;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic setcfg(input [31:0] c);
    cfg_we = 1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic dummy();
    fill(20'hFFFFF, 2'd3, '0, '0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 cfg", cfg_q == 32'h20000010, cfg_q, 32'h20000010);
    chk("R1 cnt", stat_hits == 0 && stat_misses == 0, stat_hits + stat_misses, 0);
    look(20'd5, 2'd1);
    chk("R1 empty", !r_hit && !r_stall, {r_hit, r_stall}, 0);
    // R8 second miss stalls
    look(20'd6, 2'd1);
    chk("R8 miss stall", r_stall && !r_hit, {r_stall, r_hit}, 2'b10);
    // R10 + R2
    fill(20'd5, 2'd1, 20'h12345, 3'd5);
    look(20'd5, 2'd1);
    chk("R2 hit", r_hit && r_pfn == 20'h12345 && r_attr == 3'd5 && !r_stall, {r_hit, r_pfn, r_attr}, {1'b1, 20'h12345, 3'd5});
    expect_miss("R2 asid", 20'd5, 2'd2);
    fill(20'd6, 2'd1, 20'h66, 3'd1);
    chk("R9 off", stat_hits == 0 && stat_misses == 0, stat_hits + stat_misses, 0);

    // R9 counters with stats enabled
    setcfg(32'hA0000010);
    expect_hit("R2 a", 20'd5, 2'd1, 20'h12345);
    expect_hit("R2 b", 20'd6, 2'd1, 20'h66);
    expect_hit("R2 c", 20'd5, 2'd1, 20'h12345);
    expect_miss("R9 miss", 20'd7, 2'd0);
    look(20'd8, 2'd0);
    chk("R8 stall2", r_stall, r_stall, 1);
    look(20'd6, 2'd1);
    chk("R8 hum hit", r_hit && !r_stall && r_pfn == 20'h66, {r_hit, r_stall}, 2'b10);
    chk("R9 hits", stat_hits == 4, stat_hits, 4);
    chk("R9 misses", stat_misses == 1, stat_misses, 1);
    fill(20'd7, 2'd0, 20'h77, 3'd2);

    // R8 hit-under-miss off
    setcfg(32'h80000010);
    expect_miss("R8 off miss", 20'd9, 2'd0);
    look(20'd5, 2'd1);
    chk("R8 off stall", r_stall && !r_hit, {r_stall, r_hit}, 2'b10);
    fill(20'd9, 2'd0, 20'h99, 3'd0);
    expect_hit("R10 after fill", 20'd5, 2'd1, 20'h12345);
    chk("R9 hits2", stat_hits == 5, stat_hits, 5);
    chk("R9 misses2", stat_misses == 2, stat_misses, 2);
    setcfg(32'h20000010);
    expect_hit("R2 d", 20'd5, 2'd1, 20'h12345);
    chk("R9 frozen", stat_hits == 5, stat_hits, 5);

    // R5 global flush
    flush(32'h0);
    expect_miss("R5 all", 20'd5, 2'd1);
    dummy();
    flush(32'h0);

    // R3 round robin
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 2'd0, 20'h1000 + 20'(i), 3'd0);
    fill(20'h200, 2'd0, 20'h2000, 3'd0);
    expect_hit("R3 keep1", 20'h101, 2'd0, 20'h1001);
    expect_hit("R3 keep15", 20'h10F, 2'd0, 20'h100F);
    expect_hit("R3 new", 20'h200, 2'd0, 20'h2000);
    expect_miss("R3 evict0", 20'h100, 2'd0);
    fill(20'h100, 2'd0, 20'h3000, 3'd0);
    expect_hit("R3 refill", 20'h100, 2'd0, 20'h3000);
    expect_miss("R3 evict1", 20'h101, 2'd0);
    // R4 overwrite in place
    fill(20'h102, 2'd0, 20'h4000, 3'd7);
    look(20'h102, 2'd0);
    chk("R4 overwrite", r_hit && r_pfn == 20'h4000 && r_attr == 3'd7, {r_hit, r_pfn}, {1'b1, 20'h4000});
    fill(20'h300, 2'd0, 20'h5000, 3'd0);
    expect_hit("R4 next", 20'h300, 2'd0, 20'h5000);
    expect_miss("R4 no dup", 20'h102, 2'd0);
    expect_hit("R4 line3", 20'h103, 2'd0, 20'h1003);
    dummy();

    // R3 active line count
    setcfg(32'h20000004);
    flush(32'h0);
    for (int i = 0; i < 5; i++) fill(20'h10 + 20'(i), 2'd0, 20'h10 + 20'(i), 3'd0);
    for (int i = 1; i < 5; i++) expect_hit("R3 active", 20'h10 + 20'(i), 2'd0, 20'h10 + 20'(i));
    expect_miss("R3 active wrap", 20'h10, 2'd0);
    dummy();

    // R5 R6 section and group
    setcfg(32'h20000010);
    flush(32'h0);
    fill(20'h400, 2'd0, 20'd1, 3'd0);
    fill(20'h7FF, 2'd0, 20'd2, 3'd0);
    fill(20'h800, 2'd0, 20'd3, 3'd0);
    fill(20'h404, 2'd0, 20'd4, 3'd0);
    fill(20'h401, 2'd0, 20'd5, 3'd0);
    fill(20'h400, 2'd1, 20'd6, 3'd0);
    flush(32'h80000403);
    expect_hit("R5 group spare", 20'h404, 2'd0, 20'd4);
    expect_hit("R6 other id", 20'h400, 2'd1, 20'd6);
    expect_hit("R5 group spare2", 20'h7FF, 2'd0, 20'd2);
    expect_miss("R5 group kill", 20'h401, 2'd0);
    expect_miss("R5 group kill2", 20'h400, 2'd0);
    dummy();
    flush(32'h00000402);
    expect_hit("R5 section spare", 20'h800, 2'd0, 20'd3);
    expect_miss("R5 section kill", 20'h7FF, 2'd0);
    expect_miss("R6 any id", 20'h400, 2'd1);
    dummy();
    flush(32'h00000801);
    expect_hit("R5 type1 noop", 20'h800, 2'd0, 20'd3);
    fill(20'h900, 2'd2, 20'd9, 3'd0);
    flush(32'hC0000000);
    expect_hit("R6 id flush spare", 20'h800, 2'd0, 20'd3);
    expect_miss("R6 id flush kill", 20'h900, 2'd2);

    // R7 flush and fill together
    cmd_we = 1; cmd_data = 32'h00000AA3;
    fill(20'h555, 2'd0, 20'h555, 3'd0);
    cmd_we = 0;
    expect_hit("R7 unrelated", 20'h800, 2'd0, 20'd3);
    expect_miss("R7 fill dropped", 20'h555, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule